// File: doc/BRIEF.md
# Signed Halfword Load Unit

This unit executes one instruction family: the load that reads a 16-bit value from memory, sign-extends it to 32 bits and writes it to a destination register. It accepts encodings from two instruction sets. One is a fixed 32-bit set with a condition field. The other is a compact set that mixes 16-bit and 32-bit instructions. The `compact_mode` input selects which decoder interprets the instruction word.

When an instruction is issued, the unit drives the base and index register numbers. In the same cycle it takes the register values and the program counter, and computes both the effective address and the updated base value. For offset addressing, the effective address is the base plus or minus the offset. For pre-indexed addressing, it is the same sum and the base is also updated. For post-indexed addressing, the effective address is the unmodified base and the base is updated to the sum. For PC-literal forms, the base is the program counter rounded down to a multiple of 4.

The unit then issues one halfword read with a valid/ready request and waits for a data-valid response. In the cycle the response arrives, it presents the destination writeback and, if needed, the base writeback. Three cases end without any memory traffic and are reported by one-cycle pulses: a failed condition, an odd effective address, and an unrecognised encoding. The condition flags are never touched. The unit has no port that could change them.

Top module: `hld_unit`

## Requirements
- R1: Compact 32-bit form with bits [31:20] = 1111_1001_1011 and a base field [19:16] other than 15 reads from base + zero-extended imm12 [11:0]. The destination is [15:12]. There is no base writeback.
- R2: `rt_data` is the 16-bit response with bit 15 copied into bits 31:16. It appears with `rt_we` and `done` in the same cycle as `mem_rsp_valid`.
- R3: Compact 32-bit form with bits [31:20] = 1111_1001_0011 and [11:8] = 1100 reads from base − imm8 [7:0]. There is no writeback.
- R4: Post-indexed forms read from the unmodified base and write base ± offset back to the base register. In the compact set these are [11:8] = 1,0,U,1, with U in bit 9. In the fixed set these are P (bit 24) = 0 and W (bit 21) = 0.
- R5: Pre-indexed forms read from base ± offset and write that same value back to the base register. In the compact set these are [11:8] = 1,1,U,1. In the fixed set these are P = 1 and W = 1.
- R6: Register-offset forms add or subtract an index register, selected by `rm_idx`. The 16-bit compact form, held in [31:16], is 0101111 followed by Rm [24:22], Rn [21:19] and Rt [18:16]. The compact 32-bit form has [11:6] = 0 and shifts Rm [3:0] left by imm2 [5:4]. The fixed form has bit 22 = 0 and [11:8] = 0.
- R7: Base field 15 selects the literal form, with base = `pc` with bits 1:0 cleared. In the compact set, bit 23 selects add (1) or subtract (0) of imm12.
- R8: A fixed-set word matches when [27:25] = 000, bit 20 = 1 and [7:4] = 1111. Bit 22 = 1 selects an immediate of {[11:8],[3:0]}. U (bit 23) selects add. Base and destination are in [19:16] and [15:12].
- R9: With `cond_pass` low at issue, `done` pulses one cycle later with no memory request and no writeback.
- R10: An odd effective address pulses `align_fault` one cycle after issue. No request is made and no register is written.
- R11: An unrecognised word pulses `undef_fault` one cycle after issue, with no request. Unrecognised words include fixed P = 0 with W = 1, and any fixed-set word presented with `compact_mode` = 1.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. The writebacks occur only in the response cycle.
- R13: When the destination equals the base register, only the destination write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| issue_ready | output | 1 | Unit idle, accepts an instruction |
| instr | input | 32 | Instruction word (16-bit compact encodings in [31:16]) |
| compact_mode | input | 1 | 1 = compact set, 0 = fixed 32-bit set |
| cond_pass | input | 1 | Condition evaluated true |
| pc | input | 32 | Program counter value as read by the instruction |
| rn_idx | output | 4 | Base register read index |
| rm_idx | output | 4 | Index register read index |
| rn_val | input | 32 | Base register value |
| rm_val | input | 32 | Index register value |
| mem_req_valid | output | 1 | Halfword read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of the halfword |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| rt_we | output | 1 | Destination write enable |
| rt_idx | output | 4 | Destination register |
| rt_data | output | 32 | Sign-extended load value |
| base_we | output | 1 | Base writeback enable |
| base_idx | output | 4 | Base register to update |
| base_data | output | 32 | Updated base value |
| done | output | 1 | Instruction completed (load or condition skip) |
| align_fault | output | 1 | Odd address, instruction abandoned |
| undef_fault | output | 1 | Encoding not recognised |

## Verification
The address, writeback value and register numbers are latched at issue. A wrong decode or address choice therefore shows up on `mem_req_addr` in the first request cycle. A wrong base update shows up on `base_data` in the response cycle, at most a few cycles after issue. Control state that goes astray appears as a request where a skip or fault pulse was due, or as writebacks outside the response cycle. The bench checks each of these at the port in the cycle it is due. Each addressing mode is driven with its own base and offset, so that post-indexed and pre-indexed results differ from each other.

// File: rtl/hld_pkg.sv
package hld_pkg;
  localparam int RIDX_W = 4;
  localparam int IMM_W  = 12;
  localparam int SH_W   = 2;

  typedef struct packed {
    logic              legal;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rm;
    logic              use_rm;
    logic [SH_W-1:0]   shamt;
    logic [IMM_W-1:0]  imm;
    logic              add;
    logic              index;
    logic              wback;
    logic              literal;
  } hld_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } hld_state_e;
endpackage

// File: rtl/hld_dec_fixed.sv
module hld_dec_fixed
  import hld_pkg::*;
(
  input  logic [31:0] iw,
  output hld_dec_t    dec
);
  logic fmt_hit, pre, up, wb_bit, imm_form, fmt_ok;

  always_comb begin
    fmt_hit  = (iw[27:25] == 3'b000) && iw[20] && (iw[7:4] == 4'hF);
    pre      = iw[24];
    up       = iw[23];
    imm_form = iw[22];
    wb_bit   = iw[21];
    fmt_ok   = imm_form || (iw[11:8] == 4'h0);

    dec         = '0;
    dec.rn      = iw[19:16];
    dec.rt      = iw[15:12];
    dec.rm      = iw[3:0];
    dec.use_rm  = !imm_form;
    dec.imm     = {4'h0, iw[11:8], iw[3:0]};
    dec.add     = up;
    dec.index   = pre;
    dec.wback   = !pre || wb_bit;
    dec.literal = (iw[19:16] == 4'hF);
    // P=0 with W=1 is a different operation; literal base may not be
    // updated and has no register-offset form.
    dec.legal   = fmt_hit && fmt_ok && !(!pre && wb_bit)
                  && !(dec.literal && (dec.wback || !imm_form));
  end
endmodule

// File: rtl/hld_dec_compact.sv
module hld_dec_compact
  import hld_pkg::*;
(
  input  logic [31:0] iw,
  output hld_dec_t    dec
);
  logic is_short, is_wide;

  always_comb begin
    is_short = (iw[31:25] == 7'b0101111);
    is_wide  = (iw[31:24] == 8'hF9) && (iw[22:20] == 3'b011);

    dec = '0;
    if (is_short) begin
      dec.legal  = 1'b1;
      dec.rm     = {1'b0, iw[24:22]};
      dec.rn     = {1'b0, iw[21:19]};
      dec.rt     = {1'b0, iw[18:16]};
      dec.use_rm = 1'b1;
      dec.add    = 1'b1;
      dec.index  = 1'b1;
    end else if (is_wide) begin
      dec.rn    = iw[19:16];
      dec.rt    = iw[15:12];
      dec.index = 1'b1;
      if (iw[19:16] == 4'hF) begin
        dec.legal   = 1'b1;
        dec.literal = 1'b1;
        dec.imm     = iw[11:0];
        dec.add     = iw[23];
      end else if (iw[23]) begin
        dec.legal = 1'b1;
        dec.imm   = iw[11:0];
        dec.add   = 1'b1;
      end else if (iw[11:8] == 4'b1100) begin
        dec.legal = 1'b1;
        dec.imm   = {4'h0, iw[7:0]};
        dec.add   = 1'b0;
      end else if (iw[11] && iw[8]) begin
        dec.legal = 1'b1;
        dec.imm   = {4'h0, iw[7:0]};
        dec.add   = iw[9];
        dec.index = iw[10];
        dec.wback = 1'b1;
      end else if (iw[11:6] == 6'd0) begin
        dec.legal  = 1'b1;
        dec.use_rm = 1'b1;
        dec.rm     = iw[3:0];
        dec.shamt  = iw[5:4];
        dec.add    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hld_agen.sv
module hld_agen
  import hld_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  hld_dec_t        dec,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] upd_base
);
  logic [XLEN-1:0] base, offset, sum;

  always_comb begin
    base     = dec.literal ? {pc[XLEN-1:2], 2'b00} : base_val;
    offset   = dec.use_rm ? (index_val << dec.shamt) : XLEN'(dec.imm);
    sum      = dec.add ? (base + offset) : (base - offset);
    eff_addr = dec.index ? sum : base;
    upd_base = sum;
  end
endmodule

// File: rtl/hld_unit.sv
module hld_unit
  import hld_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int HALF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [31:0]       instr,
  input  logic              compact_mode,
  input  logic              cond_pass,
  input  logic [XLEN-1:0]   pc,
  output logic [RIDX_W-1:0] rn_idx,
  output logic [RIDX_W-1:0] rm_idx,
  input  logic [XLEN-1:0]   rn_val,
  input  logic [XLEN-1:0]   rm_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [HALF-1:0]   mem_rsp_data,
  output logic              rt_we,
  output logic [RIDX_W-1:0] rt_idx,
  output logic [XLEN-1:0]   rt_data,
  output logic              base_we,
  output logic [RIDX_W-1:0] base_idx,
  output logic [XLEN-1:0]   base_data,
  output logic              done,
  output logic              align_fault,
  output logic              undef_fault
);
  localparam int EXT_W = XLEN - HALF;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  hld_dec_t dec_fix, dec_cmp, dec;
  hld_dec_fixed   u_dec_fixed   (.iw(instr), .dec(dec_fix));
  hld_dec_compact u_dec_compact (.iw(instr), .dec(dec_cmp));
  assign dec    = compact_mode ? dec_cmp : dec_fix;
  assign rn_idx = dec.rn;
  assign rm_idx = dec.rm;

  logic [XLEN-1:0] eff_addr, upd_base;
  hld_agen #(.XLEN(XLEN)) u_agen (
    .dec(dec), .base_val(rn_val), .index_val(rm_val), .pc(pc),
    .eff_addr(eff_addr), .upd_base(upd_base)
  );

  hld_state_e        state_q, state_d;
  logic [XLEN-1:0]   addr_q, wbval_q;
  logic [RIDX_W-1:0] rt_q, rn_q;
  logic              wb_q;
  logic              skip_q, skip_d, af_q, af_d, uf_q, uf_d;
  logic              load_en, accept, finish;

  assign accept = issue_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    skip_d  = 1'b0;
    af_d    = 1'b0;
    uf_d    = 1'b0;
    load_en = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (!cond_pass)       skip_d = 1'b1;
        else if (!dec.legal)  uf_d   = 1'b1;
        else if (eff_addr[0]) af_d   = 1'b1;
        else begin
          load_en = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ:  if (mem_req_ready) state_d = ST_RSP;
      ST_RSP:  if (mem_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      skip_q  <= 1'b0;
      af_q    <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
      af_q    <= af_d;
      uf_q    <= uf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q  <= '0;
      wbval_q <= '0;
      rt_q    <= '0;
      rn_q    <= '0;
      wb_q    <= 1'b0;
    end else if (load_en) begin
      addr_q  <= eff_addr;
      wbval_q <= upd_base;
      rt_q    <= dec.rt;
      rn_q    <= dec.rn;
      wb_q    <= dec.wback;
    end
  end

  assign finish        = (state_q == ST_RSP) && mem_rsp_valid;
  assign issue_ready   = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign rt_we         = finish;
  assign rt_idx        = rt_q;
  assign rt_data       = {{EXT_W{mem_rsp_data[HALF-1]}}, mem_rsp_data};
  assign base_we       = finish && wb_q && (rn_q != rt_q);
  assign base_idx      = rn_q;
  assign base_data     = wbval_q;
  assign done          = finish || skip_q;
  assign align_fault   = af_q;
  assign undef_fault   = uf_q;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R10
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req_valid |-> !mem_req_addr[0]);
  // R13
  base_prio_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    base_we |-> (base_idx != rt_idx) && rt_we);
  // R9
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    issue_valid && issue_ready && !cond_pass |=> done && !mem_req_valid && !rt_we);
  // R11
  end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({done, align_fault, undef_fault}));
  // R12
  wb_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid && !issue_ready);
endmodule

// File: tb/test_hld_unit.sv
module test_hld_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, issue_ready, compact_mode, cond_pass;
  logic [31:0] instr, pc;
  logic [3:0]  rn_idx, rm_idx, rt_idx, base_idx;
  logic [31:0] rn_val, rm_val, mem_req_addr, rt_data, base_data;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        rt_we, base_we, done, align_fault, undef_fault;

  logic [31:0] regs [16];
  int nvec = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rn_val = regs[rn_idx];
  assign rm_val = regs[rm_idx];

  hld_unit i_hld_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .instr(instr), .compact_mode(compact_mode), .cond_pass(cond_pass), .pc(pc),
    .rn_idx(rn_idx), .rm_idx(rm_idx), .rn_val(rn_val), .rm_val(rm_val),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data),
    .base_we(base_we), .base_idx(base_idx), .base_data(base_data), .done(done),
    .align_fault(align_fault), .undef_fault(undef_fault)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-clock model: writebacks only when the bench is answering a read (R12)
  always @(negedge clk) begin
    if (rst_n && !mem_rsp_valid) begin
      chk("R12", "stray rt_we", {31'd0, rt_we}, 32'd0);
      chk("R12", "stray base_we", {31'd0, base_we}, 32'd0);
    end
  end

  // kind: 0 load, 1 condition skip, 2 alignment fault, 3 undefined
  task automatic run_op(string tag, logic mode, logic cnd, logic [31:0] iw,
                        logic [31:0] pcv, int kind, logic [31:0] ex_addr,
                        logic [15:0] mdata, logic [3:0] ex_rt, logic ex_bwe,
                        logic [3:0] ex_bidx, logic [31:0] ex_bval, int stall);
    logic [31:0] ex_rt_val;
    ex_rt_val = {{16{mdata[15]}}, mdata};
    @(negedge clk);
    chk(tag, "issue_ready", {31'd0, issue_ready}, 32'd1);
    issue_valid = 1'b1; compact_mode = mode; cond_pass = cnd; instr = iw; pc = pcv;
    @(negedge clk);
    issue_valid = 1'b0;
    case (kind)
      1: begin
        chk(tag, "done", {31'd0, done}, 32'd1);
        chk(tag, "req", {31'd0, mem_req_valid}, 32'd0);
      end
      2: begin
        chk(tag, "align_fault", {31'd0, align_fault}, 32'd1);
        chk(tag, "req", {31'd0, mem_req_valid}, 32'd0);
      end
      3: begin
        chk(tag, "undef_fault", {31'd0, undef_fault}, 32'd1);
        chk(tag, "req", {31'd0, mem_req_valid}, 32'd0);
      end
      default: begin
        chk(tag, "req", {31'd0, mem_req_valid}, 32'd1);
        chk(tag, "addr", mem_req_addr, ex_addr);
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(tag, "req held", {31'd0, mem_req_valid}, 32'd1);
          chk(tag, "addr held", mem_req_addr, ex_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(tag, "req dropped", {31'd0, mem_req_valid}, 32'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = mdata;
        #1;
        chk(tag, "rt_we", {31'd0, rt_we}, 32'd1);
        chk(tag, "rt_idx", {28'd0, rt_idx}, {28'd0, ex_rt});
        chk(tag, "rt_data", rt_data, ex_rt_val);
        chk(tag, "done", {31'd0, done}, 32'd1);
        chk(tag, "base_we", {31'd0, base_we}, {31'd0, ex_bwe});
        if (ex_bwe) begin
          chk(tag, "base_idx", {28'd0, base_idx}, {28'd0, ex_bidx});
          chk(tag, "base_data", base_data, ex_bval);
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    endcase
    if (kind != 0) begin
      @(negedge clk);
      chk(tag, "quiet after", {30'd0, mem_req_valid, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) regs[k] = 32'h100 * k;
    regs[15] = 32'hDEAD_BEE0;
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; compact_mode = 1'b0;
    cond_pass = 1'b1; pc = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk("R12", "reset req", {31'd0, mem_req_valid}, 32'd0);
    chk("R9", "reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1, R2: imm12 add, negative and positive halfwords
    run_op("R1", 1, 1, 32'hF9B23010, 0, 0, 32'h210, 16'h8001, 4'd3, 0, 0, 0, 0);
    run_op("R2", 1, 1, 32'hF9B23FFE, 0, 0, 32'h11FE, 16'h7FFF, 4'd3, 0, 0, 0, 1);
    // R3: imm8 subtract
    run_op("R3", 1, 1, 32'hF9345C20, 0, 0, 32'h3E0, 16'hC000, 4'd5, 0, 0, 0, 0);
    // R4: post-index add, with backpressure
    run_op("R4", 1, 1, 32'hF9367B08, 0, 0, 32'h600, 16'h0042, 4'd7, 1, 4'd6, 32'h608, 2);
    // R5: pre-index subtract with writeback
    run_op("R5", 1, 1, 32'hF9389D04, 0, 0, 32'h7FC, 16'hFFFF, 4'd9, 1, 4'd8, 32'h7FC, 0);
    // R13: destination equals base
    run_op("R13", 1, 1, 32'hF9388D04, 0, 0, 32'h7FC, 16'h1234, 4'd8, 0, 0, 0, 0);
    // R6: shifted register, 16-bit register form
    run_op("R6", 1, 1, 32'hF9312023, 0, 0, 32'hD00, 16'h8000, 4'd2, 0, 0, 0, 0);
    run_op("R6", 1, 1, 32'h5E530000, 0, 0, 32'h300, 16'h00FF, 4'd3, 0, 0, 0, 0);
    // R7: literal add and subtract, PC rounded down
    run_op("R7", 1, 1, 32'hF9BF4006, 32'h8003, 0, 32'h8006, 16'h5555, 4'd4, 0, 0, 0, 0);
    run_op("R7", 1, 1, 32'hF93F4006, 32'h8002, 0, 32'h7FFA, 16'hAAAA, 4'd4, 0, 0, 0, 0);
    // R8: fixed immediate offset
    run_op("R8", 0, 1, 32'hE1DAB3FA, 0, 0, 32'hA3A, 16'hFF00, 4'd11, 0, 0, 0, 0);
    // R4: fixed post-index subtract
    run_op("R4", 0, 1, 32'hE05C11F0, 0, 0, 32'hC00, 16'h0010, 4'd1, 1, 4'd12, 32'hBF0, 0);
    // R5, R6: fixed pre-index register form
    run_op("R5", 0, 1, 32'hE1BDE0F2, 0, 0, 32'hF00, 16'h9000, 4'd14, 1, 4'd13, 32'hF00, 1);
    // R7: fixed literal
    run_op("R7", 0, 1, 32'hE1DF01F2, 32'h9006, 0, 32'h9016, 16'h0001, 4'd0, 0, 0, 0, 0);
    // R9: condition fails
    run_op("R9", 1, 0, 32'hF9B23010, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R10: odd address
    run_op("R10", 1, 1, 32'hF9B23011, 0, 2, 0, 0, 0, 0, 0, 0, 0);
    // R11: undefined encodings
    run_op("R11", 1, 1, 32'hF9300A00, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    run_op("R11", 0, 1, 32'hE07000F0, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    run_op("R11", 1, 1, 32'hE1DAB3FA, 0, 3, 0, 0, 0, 0, 0, 0, 0);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule